// File: doc/BRIEF.md
# Byte-Register SPI Master

This block is an SPI master that software runs through a small register file of eight-bit registers. A byte written to the data address goes into a four-entry transmit queue. When shifting is enabled, the shifter pops the queue one byte at a time and runs a full-duplex exchange on the serial pins. It sends the byte MSB first on `mosi` and collects eight bits from `miso` at the same time. Each collected byte lands in a two-entry receive queue. Software pops that queue by reading the same data address. A read-only transfer is a write of 0x00 followed by a read.

The serial bit rate comes from an external divider. That divider receives a four-bit rate code from this block and returns a one-cycle `half_tick` pulse for every serial half period. Software drives the four chip-select lines directly. A mode-fault sense input stops the master and latches an error flag, which also drives `irq`.

Inside the block, the transmit queue feeds the shifter over a valid/ready handshake. The queue presents a byte whenever it is not empty, and the shifter takes it only while enabled and idle. The register port applies no back-pressure: a data write to a full transmit queue is dropped. A byte that finishes while the receive queue is full is discarded.

Top module: `spi_byte_master`

## Requirements
- R1: After reset the registers read as follows: address 0 (control) 0x00, 1 (status) 0x05, 3 (extension) 0x00, 4 (parameter) 0x40, 5 (chip select) 0x00 and 6 (timing) 0x01. At the same time `cs_n` is 4'hF, `sclk` is 0, `irq` is 0 and `div_code` is 0.
- R2: The transmit queue holds 4 bytes, and a data write (address 2) to a full queue is ignored. Status bit 2 means the transmit queue is empty and bit 3 means it is full.
- R3: Each queued byte is shifted out MSB first on `mosi` while one byte is shifted in from `miso`. Every byte takes 16 `sclk` edges, one per `half_tick`.
- R4: `sclk` idles at control bit 3 (polarity). When control bit 2 (phase) is 0, `miso` is sampled on the first, third and later odd-numbered edges of a byte. When it is 1, sampling happens on the second, fourth and later even-numbered edges, and `mosi` changes on the edges in between.
- R5: The receive queue holds 2 bytes, and a byte that completes while it is full is discarded. A data read returns the oldest byte and pops it. Status bit 0 means the receive queue is empty and bit 1 means it is full.
- R6: A data read while the receive queue is empty returns the byte most recently popped and leaves the queue state unchanged.
- R7: While control bit 6 (enable) is 0, no shifting starts and queued bytes wait. Clearing the bit stops a byte in flight.
- R8: In the chip-select register, bit n (for n = 0 to 3) hands line n to software and bit n+4 sets its level. A line not handed over drives `cs_n[n]` high.
- R9: `mfault` high while enable is set has four effects on the next cycle: status bit 4 is set, `irq` rises, control bit 6 clears and the byte in flight is dropped. Writing 1 to status bit 4 clears the flag. A new fault in the same cycle as that write wins.
- R10: `div_code` equals {extension[1:0], control[1:0]}. The parameter and timing registers read back the value last written.
- R11: Status bit 7 is 1 while a byte is being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at address 2) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| half_tick | input | 1 | Serial half-period pulse from the rate divider |
| mfault | input | 1 | Mode-fault sense |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Chip-select lines |
| irq | output | 1 | Interrupt request, follows the fault flag |
| div_code | output | 4 | Rate code for the external divider |

## Verification
Two pairs of events can land in one clock edge. The first pair is a mode fault and a software write that clears the fault flag. The bench re-enables the master, then in a single cycle raises `mfault` and writes 1 to status bit 4. It expects the flag and `irq` to stay set, and a later write on its own to clear them. The second pair is a completed byte reaching a full receive queue. The bench queues four bytes behind a disabled master, enables it, and expects the first two received bytes to read back, then a repeat of the last one with the empty flag set.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;
  localparam logic [2:0] ADR_CTRL   = 3'd0;
  localparam logic [2:0] ADR_STAT   = 3'd1;
  localparam logic [2:0] ADR_DATA   = 3'd2;
  localparam logic [2:0] ADR_EXT    = 3'd3;
  localparam logic [2:0] ADR_PARAM  = 3'd4;
  localparam logic [2:0] ADR_CSEL   = 3'd5;
  localparam logic [2:0] ADR_TIMING = 3'd6;

  localparam int CB_EN   = 6;
  localparam int CB_CPOL = 3;
  localparam int CB_CPHA = 2;

  localparam int SB_RXE  = 0;
  localparam int SB_RXF  = 1;
  localparam int SB_TXE  = 2;
  localparam int SB_TXF  = 3;
  localparam int SB_FLT  = 4;
  localparam int SB_BUSY = 7;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign head  = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int DW  = 8,
  localparam int EW = $clog2(2 * DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          abort,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          half_tick,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_data,
  output logic          tx_ready,
  input  logic          miso,
  output logic          sclk,
  output logic          mosi,
  output logic          active,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data
);
  logic          phase;
  logic [EW-1:0] edge_q;
  logic [DW-1:0] txs, rxs;

  assign tx_ready = en && !abort && !active;
  assign sclk     = cpol ^ phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      phase    <= 1'b0;
      edge_q   <= '0;
      txs      <= '0;
      rxs      <= '0;
      mosi     <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (abort || !en) begin
        active <= 1'b0;
        phase  <= 1'b0;
        edge_q <= '0;
      end else if (!active) begin
        if (tx_valid) begin
          active <= 1'b1;
          phase  <= 1'b0;
          edge_q <= '0;
          if (!cpha) begin
            mosi <= tx_data[DW-1];
            txs  <= {tx_data[DW-2:0], 1'b0};
          end else begin
            txs  <= tx_data;
          end
        end
      end else if (half_tick) begin
        phase  <= ~phase;
        edge_q <= edge_q + 1'b1;
        if (edge_q[0] == cpha) begin
          rxs <= {rxs[DW-2:0], miso};
        end else begin
          mosi <= txs[DW-1];
          txs  <= {txs[DW-2:0], 1'b0};
        end
        if (edge_q == EW'(2 * DW - 1)) begin
          active   <= 1'b0;
          rx_valid <= 1'b1;
          rx_data  <= cpha ? {rxs[DW-2:0], miso} : rxs;
        end
      end
    end
  end
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int DW       = 8,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 2,
  localparam int NCS     = DW / 2,
  localparam int TCW     = $clog2(TX_DEPTH + 1),
  localparam int RCW     = $clog2(RX_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     reg_addr,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  input  logic           half_tick,
  input  logic           mfault,
  output logic           sclk,
  output logic           mosi,
  input  logic           miso,
  output logic [NCS-1:0] cs_n,
  output logic           irq,
  output logic [3:0]     div_code
);
  import spi_byte_pkg::*;

  logic [DW-1:0] ctrl_q, ext_q, param_q, timing_q, csel_q, last_q;
  logic          fault_q;
  logic [DW-1:0] tx_head, rx_head, sh_rx_data, stat;
  logic          tx_empty, tx_full, rx_empty, rx_full;
  logic [TCW-1:0] tx_count;
  logic [RCW-1:0] rx_count;
  logic          sh_ready, sh_active, sh_rx_valid;

  wire wr_data   = reg_wr && (reg_addr == ADR_DATA);
  wire rd_data   = reg_rd && (reg_addr == ADR_DATA);
  wire fault_hit = mfault && ctrl_q[CB_EN];
  wire tx_take   = sh_ready && !tx_empty;
  wire rx_pop    = rd_data && !rx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      ext_q    <= '0;
      param_q  <= DW'(8'h40);
      timing_q <= DW'(8'h01);
      csel_q   <= '0;
      fault_q  <= 1'b0;
      last_q   <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          ADR_CTRL:   ctrl_q   <= reg_wdata;
          ADR_EXT:    ext_q    <= reg_wdata;
          ADR_PARAM:  param_q  <= reg_wdata;
          ADR_CSEL:   csel_q   <= reg_wdata;
          ADR_TIMING: timing_q <= reg_wdata;
          ADR_STAT:   if (reg_wdata[SB_FLT]) fault_q <= 1'b0;
          default: ;
        endcase
      end
      if (fault_hit) begin
        ctrl_q[CB_EN] <= 1'b0;
        fault_q       <= 1'b1;
      end
      if (rx_pop) last_q <= rx_head;
    end
  end

  spi_byte_fifo #(.DW(DW), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(wr_data && !tx_full), .din(reg_wdata),
    .pop(tx_take), .head(tx_head),
    .empty(tx_empty), .full(tx_full), .count(tx_count)
  );

  spi_byte_fifo #(.DW(DW), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(sh_rx_valid && !rx_full), .din(sh_rx_data),
    .pop(rx_pop), .head(rx_head),
    .empty(rx_empty), .full(rx_full), .count(rx_count)
  );

  spi_byte_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .en(ctrl_q[CB_EN]), .abort(fault_hit),
    .cpol(ctrl_q[CB_CPOL]), .cpha(ctrl_q[CB_CPHA]),
    .half_tick(half_tick),
    .tx_valid(!tx_empty), .tx_data(tx_head), .tx_ready(sh_ready),
    .miso(miso), .sclk(sclk), .mosi(mosi), .active(sh_active),
    .rx_valid(sh_rx_valid), .rx_data(sh_rx_data)
  );

  always_comb begin
    stat          = '0;
    stat[SB_RXE]  = rx_empty;
    stat[SB_RXF]  = rx_full;
    stat[SB_TXE]  = tx_empty;
    stat[SB_TXF]  = tx_full;
    stat[SB_FLT]  = fault_q;
    stat[SB_BUSY] = sh_active;
  end

  always_comb begin
    case (reg_addr)
      ADR_CTRL:   reg_rdata = ctrl_q;
      ADR_STAT:   reg_rdata = stat;
      ADR_DATA:   reg_rdata = rx_empty ? last_q : rx_head;
      ADR_EXT:    reg_rdata = ext_q;
      ADR_PARAM:  reg_rdata = param_q;
      ADR_CSEL:   reg_rdata = csel_q;
      ADR_TIMING: reg_rdata = timing_q;
      default:    reg_rdata = '0;
    endcase
  end

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_n[i] = csel_q[i] ? csel_q[i + NCS] : 1'b1;
  end

  assign irq      = fault_q;
  assign div_code = {ext_q[1:0], ctrl_q[1:0]};
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk #(
  parameter int TXD = 4,
  parameter int RXD = 2,
  parameter int TCW = 3,
  parameter int RCW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mfault,
  input logic           en,
  input logic           cpol,
  input logic           sclk,
  input logic           active,
  input logic           irq,
  input logic           clr_req,
  input logic [TCW-1:0] tx_cnt,
  input logic [RCW-1:0] rx_cnt
);
  // R2
  tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= TCW'(TXD));

  // R5
  rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= RCW'(RXD));

  // R4
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (sclk == cpol));

  // R7
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !active);

  // R9
  fault_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mfault && en) |=> irq);

  // R9
  fault_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mfault && en) |=> (!active && !en));

  // R9
  fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !(mfault && en)) |=> !irq);
endmodule

bind spi_byte_master spi_byte_master_chk #(
  .TXD(TX_DEPTH), .RXD(RX_DEPTH), .TCW(TCW), .RCW(RCW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mfault(mfault), .en(ctrl_q[6]),
  .cpol(ctrl_q[3]), .sclk(sclk), .active(sh_active), .irq(irq),
  .clr_req(reg_wr && (reg_addr == 3'd1) && reg_wdata[4]),
  .tx_cnt(tx_count), .rx_cnt(rx_count)
);

// File: tb/spi_byte_master_test.sv
module spi_byte_master_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic half_tick = 1'b0, mfault = 1'b0, miso = 1'b0;
  logic sclk, mosi, irq;
  logic [3:0] cs_n, div_code;

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic bcpol = 0, bcpha = 0;
  logic [7:0] exp_mosi[$];
  logic [7:0] rxmodel[$];
  logic [7:0] last_rx = 8'h00;
  logic [7:0] slave_tx = 8'h00, slave_rx = 8'h00;
  int kbit = 0, ecnt = 0;
  logic ph_prev = 0;

  always #2.5 clk = ~clk;

  spi_byte_master uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .half_tick(half_tick), .mfault(mfault), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n), .irq(irq), .div_code(div_code)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_cs(input logic [7:0] r);
    logic [3:0] v;
    for (int i = 0; i < 4; i++) v[i] = r[i] ? r[i+4] : 1'b1;
    return v;
  endfunction

  function automatic logic [3:0] exp_div(input logic [7:0] c, input logic [7:0] e);
    return {e[1:0], c[1:0]};
  endfunction

  // divider stand-in: one pulse every 4 clocks
  initial begin
    int t = 0;
    forever begin
      @(negedge clk);
      t = (t + 1) % 4;
      half_tick = (t == 0);
    end
  end

  // serial slave model: samples mosi and drives miso per R3/R4
  always @(negedge clk) begin
    logic ph;
    if (rst_n) begin
      ph = sclk ^ bcpol;
      if (ph != ph_prev) begin
        if ((ecnt % 2) == int'(bcpha)) begin
          slave_rx = {slave_rx[6:0], mosi};
          kbit++;
          if (kbit == 8) begin
            if (exp_mosi.size() > 0) check("R3 mosi byte", slave_rx, exp_mosi.pop_front());
            else check("R3 unexpected byte", slave_rx, 32'hx);
            if (rxmodel.size() < 2) rxmodel.push_back(slave_tx);
            slave_tx = 8'($urandom);
            kbit = 0;
          end
          miso = slave_tx[7 - kbit];
        end
        ecnt = (ecnt + 1) % 16;
      end
      ph_prev = ph;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
    if (a == 3'd0) begin bcpol = d[3]; bcpha = d[2]; end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic send(input logic [7:0] d);
    exp_mosi.push_back(d);
    wr(3'd2, d);
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    do rd(3'd1, s); while ((s & 8'h84) != 8'h04);
    repeat (3) @(negedge clk);
  endtask

  task automatic rd_data_chk(input string req);
    logic [7:0] v, e;
    if (rxmodel.size() > 0) begin e = rxmodel.pop_front(); last_rx = e; end
    else e = last_rx;
    rd(3'd2, v);
    check(req, v, e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, c, e;
    void'($urandom(32'h5eed));
    slave_tx = 8'($urandom);
    miso = slave_tx[7];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 cs_n", cs_n, 4'hF);
    check("R1 sclk", sclk, 1'b0);
    check("R1 irq", irq, 1'b0);
    check("R1 div_code", div_code, 4'h0);
    rd(3'd0, v); check("R1 control", v, 8'h00);
    rd(3'd1, v); check("R1 status", v, 8'h05);
    rd(3'd3, v); check("R1 extension", v, 8'h00);
    rd(3'd4, v); check("R1 parameter", v, 8'h40);
    rd(3'd5, v); check("R1 chip select", v, 8'h00);
    rd(3'd6, v); check("R1 timing", v, 8'h01);

    // R10 rate code and plain registers
    wr(3'd3, 8'h02); wr(3'd0, 8'h51);
    #1 check("R10 div_code", div_code, exp_div(8'h51, 8'h02));
    wr(3'd4, 8'hA7); rd(3'd4, v); check("R10 parameter readback", v, 8'hA7);
    wr(3'd6, 8'h3C); rd(3'd6, v); check("R10 timing readback", v, 8'h3C);

    // R8 chip selects, directed then random
    wr(3'd5, 8'h01); #1 check("R8 cs low", cs_n, 4'hE);
    wr(3'd5, 8'h11); #1 check("R8 cs high", cs_n, 4'hF);
    wr(3'd5, 8'h06); #1 check("R8 two lines", cs_n, 4'h9);
    for (int i = 0; i < 6; i++) begin
      c = 8'($urandom);
      wr(3'd5, c); #1 check("R8 cs random", cs_n, exp_cs(c));
    end

    // R11 busy while shifting
    send(8'h5A);
    repeat (3) @(negedge clk);
    rd(3'd1, v); check("R11 busy bit", v[7], 1'b1);
    wait_idle();
    rd_data_chk("R3 first byte");

    // R7 disabled: byte waits
    wr(3'd0, 8'h11);
    send(8'hC3);
    repeat (20) @(negedge clk);
    rd(3'd1, v); check("R7 held in queue", v, 8'h01);
    check("R7 sclk idle", sclk, 1'b0);
    wr(3'd0, 8'h51);
    wait_idle();
    rd_data_chk("R7 after enable");

    // R3 R4 random modes and bytes
    for (int it = 0; it < 40; it++) begin
      int n;
      c = 8'h40 | 8'($urandom % 16);
      e = 8'($urandom % 4);
      wr(3'd3, e); wr(3'd0, c);
      #1 check("R4 idle level", sclk, c[3]);
      check("R10 div random", div_code, exp_div(c, e));
      n = 1 + int'($urandom % 2);
      for (int j = 0; j < n; j++) send((it % 5 == 0) ? 8'h00 : 8'($urandom));
      wait_idle();
      for (int j = 0; j < n; j++) rd_data_chk("R3 R4 readback");
    end

    // R2 R5 R6 burst: full transmit queue, overflowing receive queue
    wr(3'd0, 8'h1C);
    for (int j = 0; j < 4; j++) send(8'($urandom));
    wr(3'd2, 8'hEE);
    rd(3'd1, v); check("R2 tx full flag", v, 8'h09);
    wr(3'd0, 8'h5C);
    wait_idle();
    rd(3'd1, v); check("R5 rx full flag", v, 8'h06);
    rd_data_chk("R5 oldest");
    rd_data_chk("R5 second");
    rd_data_chk("R6 empty repeat");
    rd(3'd1, v); check("R6 status unchanged", v, 8'h05);

    // R9 mode fault
    wr(3'd0, 8'h51);
    @(negedge clk); mfault = 1'b1; @(posedge clk); #1 mfault = 1'b0;
    check("R9 irq set", irq, 1'b1);
    rd(3'd1, v); check("R9 fault flag", v, 8'h15);
    rd(3'd0, v); check("R9 enable cleared", v, 8'h11);
    wr(3'd0, 8'h51);
    @(negedge clk);
    mfault = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h10; reg_wr = 1'b1;
    @(posedge clk); #1 mfault = 1'b0; reg_wr = 1'b0;
    check("R9 fault beats clear", irq, 1'b1);
    wr(3'd1, 8'h10);
    #1 check("R9 cleared", irq, 1'b0);
    rd(3'd1, v); check("R9 status cleared", v, 8'h05);

    check("R3 all bytes seen", exp_mosi.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule